// File: doc/BRIEF.md
# Paired-Slot Round-Robin Memory Arbiter

This block decides, once per clock, which of 32 cores may use a single shared memory port. A free-running slot counter walks through 32 slots. Each slot belongs to one core, so under plain operation every core gets one turn per rotation. The memory datapath is not part of the block. It only produces the registered grant that steers that datapath.

Cores whose numbers differ by half the core count are partners: core n is paired with core n+16. A partner may take a slot that its owner does not use. The upper core of a pair can hand its own slot to the lower core through a per-core yield setting. The lower core can let the upper core use its slot, when the lower core has no request pending, through a per-core donate setting. Either way, one core of a pair can reach one access every 16 cycles instead of one every 32.

The yield and donate settings are captured into registers. Each request line is sampled in the slot it applies to. The grant comes out as a one-hot vector together with the binary number of the granted core.

Top module: `pairslot_arbiter`

## Requirements
- R1: While reset is high and in the cycle after it, the grant vector is all zero and the grant index is 0. The slot counter restarts at slot 0, and the captured yield and donate settings are cleared.
- R2: The slot counter advances by one every clock and wraps from 31 to 0. With every core requesting and no yield or donate set, the granted index equals the slot number of the previous cycle.
- R3: The owner of slot s is core s. Its partner is core s+16 for s<16, and core s-16 for s>=16. A grant in slot s only ever goes to the owner or to the partner.
- R4: Yield applies only to the upper owners, that is, slots 16 to 31. In such a slot, when the owner's captured yield bit is 1, the owner is never granted. The lower partner is granted if it requests, and otherwise no grant is issued.
- R5: In a lower slot (0 to 15), when the owner does not request and its captured donate bit is 1, the upper partner is granted if it requests.
- R6: When transfer is not permitted, the partner is never granted, even if it requests. Transfer is not permitted in an upper slot whose owner has not yielded, in a lower slot whose owner has donate clear, or in a lower slot whose owner is requesting. A requesting owner that has not yielded is always granted.
- R7: At most one grant bit is high in any cycle. The grant index always equals the position of that bit, and is 0 when no bit is high.
- R8: The grant is registered. A decision taken with the inputs of one clock appears after that edge. Yield and donate settings influence decisions one clock after they are applied. No core is granted in two consecutive cycles.
- R9: With core 3 and core 19 both requesting and core 19 yielding, core 3 is granted twice and core 19 not at all over 32 consecutive cycles. With only core 21 requesting and core 5 donating, core 21 is granted twice in 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 32 | Per-core access request, bit n for core n |
| yield_cfg | input | 32 | Per-core yield setting; used only for cores 16 to 31 |
| donate_cfg | input | 32 | Per-core donate setting; used only for cores 0 to 15 |
| gnt | output | 32 | Registered one-hot grant |
| gnt_idx | output | 5 | Number of the granted core, 0 when idle |

## Verification
The first pattern has every core requesting with no settings. It exposes the bare rotation and the wrap from slot 31 to 0, because any other schedule gives a different index sequence. Directed pairs then separate the mechanisms from one another. A yielding upper core with a requesting lower partner shows whether a yield hands the slot over. A donating idle lower core with a requesting upper partner shows whether a donation passes the slot on. With donate clear, or with the donor still requesting, both cases must fall back to one grant per rotation. Long runs of random requests, with sparse random yield and donate bits, are compared cycle by cycle against a bench model. These runs catch errors in the priority order and in the one-cycle lag of the settings.

// File: rtl/pairslot_arbiter_pkg.sv
package pairslot_arbiter_pkg;

  // Who won the current slot
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_OWNER   = 2'd1,
    SRC_PARTNER = 2'd2
  } pick_src_e;

endpackage

// File: rtl/arb_slot_ctr.sv
module arb_slot_ctr #(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst)              slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                  slot <= slot + 1'b1;
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1))); // R2

endmodule

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg #(
  parameter int NUM_CORES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] yld_in,
  input  logic [NUM_CORES-1:0] don_in,
  output logic [NUM_CORES-1:0] yld_q,
  output logic [NUM_CORES-1:0] don_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      yld_q <= '0;
      don_q <= '0;
    end else begin
      yld_q <= yld_in;
      don_q <= don_in;
    end
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import pairslot_arbiter_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic [IDX_W-1:0]     slot,
  input  logic [NUM_CORES-1:0] req,
  input  logic [NUM_CORES-1:0] yld_q,
  input  logic [NUM_CORES-1:0] don_q,
  output logic [IDX_W-1:0]     pick_idx,
  output pick_src_e            pick_src
);
  localparam logic [IDX_W-1:0] HALF = IDX_W'(NUM_CORES / 2);

  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] partner;
  logic             upper;
  logic             own_ok;
  logic             xfer_ok;

  always_comb begin
    owner   = slot;
    upper   = (slot >= HALF);
    partner = upper ? (slot - HALF) : (slot + HALF);
    // upper owners may hand their slot down; lower owners pass it up when idle
    own_ok  = req[owner] && !(upper && yld_q[owner]);
    xfer_ok = upper ? yld_q[owner] : (don_q[owner] && !req[owner]);
    if (own_ok) begin
      pick_idx = owner;
      pick_src = SRC_OWNER;
    end else if (xfer_ok && req[partner]) begin
      pick_idx = partner;
      pick_src = SRC_PARTNER;
    end else begin
      pick_idx = '0;
      pick_src = SRC_NONE;
    end
  end

endmodule

// File: rtl/pairslot_arbiter.sv
module pairslot_arbiter
  import pairslot_arbiter_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] req,
  input  logic [NUM_CORES-1:0] yield_cfg,
  input  logic [NUM_CORES-1:0] donate_cfg,
  output logic [NUM_CORES-1:0] gnt,
  output logic [IDX_W-1:0]     gnt_idx
);
  localparam logic [IDX_W-1:0] HALF = IDX_W'(NUM_CORES / 2);

  logic [IDX_W-1:0]     slot;
  logic [NUM_CORES-1:0] yld_q;
  logic [NUM_CORES-1:0] don_q;
  logic [IDX_W-1:0]     pick_idx;
  pick_src_e            pick_src;
  logic [NUM_CORES-1:0] gnt_d;

  arb_slot_ctr #(.NUM_SLOTS(NUM_CORES), .IDX_W(IDX_W)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .slot (slot)
  );

  arb_cfg_reg #(.NUM_CORES(NUM_CORES)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .yld_in (yield_cfg),
    .don_in (donate_cfg),
    .yld_q  (yld_q),
    .don_q  (don_q)
  );

  arb_pick #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_pick (
    .slot     (slot),
    .req      (req),
    .yld_q    (yld_q),
    .don_q    (don_q),
    .pick_idx (pick_idx),
    .pick_src (pick_src)
  );

  // binary pick to one-hot grant
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    assign gnt_d[c] = (pick_src != SRC_NONE) && (pick_idx == IDX_W'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt     <= '0;
      gnt_idx <= '0;
    end else begin
      gnt     <= gnt_d;
      gnt_idx <= (pick_src != SRC_NONE) ? pick_idx : '0;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R7
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> gnt[gnt_idx]); // R7
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(|gnt) |-> (gnt_idx == '0)); // R7
  AST_OWNER_OR_PARTNER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|gnt)) |->
      (gnt_idx == $past(slot) ||
       gnt_idx == (($past(slot) >= HALF) ? $past(slot) - HALF : $past(slot) + HALF))); // R3
  AST_YIELD_HONOURED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|gnt) && gnt_idx == $past(slot) && gnt_idx >= HALF)
      |-> (($past(yld_q) & gnt) == '0)); // R4
  AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|gnt)) |-> (($past(req) & gnt) != '0)); // R6
  AST_GNT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |=> ((gnt & $past(gnt)) == '0)); // R8

endmodule

// File: tb/sim_pairslot_arbiter.sv
module sim_pairslot_arbiter;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  yield_cfg = '0;
  logic [N-1:0]  donate_cfg = '0;
  logic [N-1:0]  gnt;
  logic [4:0]    gnt_idx;

  int total = 0;
  int bad   = 0;
  int m_slot = 0;
  logic [N-1:0] m_yld = '0;
  logic [N-1:0] m_don = '0;
  bit    have_exp = 0;
  int    exp_idx  = -1;
  string exp_tag  = "";
  int    seen [N];

  always #10 clk = ~clk; // 50 MHz

  pairslot_arbiter u0 (
    .clk(clk), .rst(rst), .req(req), .yield_cfg(yield_cfg),
    .donate_cfg(donate_cfg), .gnt(gnt), .gnt_idx(gnt_idx)
  );

  // expected winner of slot s, -1 when none
  function automatic int model_pick(int s, logic [N-1:0] r, logic [N-1:0] y, logic [N-1:0] d);
    int p;
    bit hi;
    hi = (s >= N/2);
    p  = hi ? s - N/2 : s + N/2;
    if (r[s] && !(hi && y[s])) return s;
    if (r[p] && (hi ? y[s] : (d[s] && !r[s]))) return p;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // called at a negedge: check last decision, drive next inputs, advance model
  task automatic cycle(logic [N-1:0] r, logic [N-1:0] y, logic [N-1:0] d, string tag);
    logic [N-1:0] ev;
    if (have_exp) begin
      ev = (exp_idx < 0) ? '0 : (N'(1) << exp_idx);
      chk(gnt == ev && gnt_idx == ((exp_idx < 0) ? 5'd0 : 5'(exp_idx)), exp_tag,
          (gnt == '0) ? -1 : int'(gnt_idx), exp_idx);
      chk($countones(gnt) <= 1 && (gnt == '0 ? gnt_idx == 0 : gnt[gnt_idx]), "R7",
          $countones(gnt), 1);
      if (gnt != '0) seen[gnt_idx]++;
    end
    req = r; yield_cfg = y; donate_cfg = d;
    exp_idx  = model_pick(m_slot, r, m_yld, m_don);
    exp_tag  = tag;
    have_exp = 1;
    m_slot = (m_slot + 1) % N;
    m_yld  = y;
    m_don  = d;
    @(negedge clk);
  endtask

  task automatic clear_seen();
    for (int i = 0; i < N; i++) seen[i] = 0;
  endtask

  // 2 settle cycles, then count grants over one full rotation
  task automatic window(logic [N-1:0] r, logic [N-1:0] y, logic [N-1:0] d, string tag);
    cycle(r, y, d, tag);
    cycle(r, y, d, tag);
    clear_seen();
    for (int i = 0; i < N; i++) cycle(r, y, d, tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(gnt == '0 && gnt_idx == 0, "R1 reset", int'(gnt_idx), 0);
    rst = 1'b0;
    // R1: held yield on core 16 in first cycle has no effect yet (cleared cfg)
    cycle('1, 32'h0001_0000, '0, "R1");
    // R2: plain rotation with wrap, 40 cycles
    for (int i = 0; i < 40; i++) cycle('1, '0, '0, "R2");

    // R4 / R9: core 19 yields to core 3
    window((N'(1) << 3) | (N'(1) << 19), N'(1) << 19, '0, "R4");
    chk(seen[3] == 2, "R9 yield double", seen[3], 2);
    chk(seen[19] == 0, "R4 yielder silent", seen[19], 0);

    // R4: yielder with lower partner idle -> nobody
    window(N'(1) << 19, N'(1) << 19, '0, "R4");
    chk(seen[19] == 0, "R4 idle partner", seen[19], 0);

    // R5 / R9: core 5 donates to core 21
    window(N'(1) << 21, '0, N'(1) << 5, "R5");
    chk(seen[21] == 2, "R9 donate double", seen[21], 2);

    // R6: no donate -> single share
    window(N'(1) << 21, '0, '0, "R6");
    chk(seen[21] == 1, "R6 no donate", seen[21], 1);

    // R6: donor still requesting keeps its slot
    window((N'(1) << 5) | (N'(1) << 21), '0, N'(1) << 5, "R6");
    chk(seen[5] == 1 && seen[21] == 1, "R6 busy donor", seen[21], 1);

    // R6: yield bit on lower core and donate bit on upper core are not used
    window((N'(1) << 2) | (N'(1) << 18), N'(1) << 2, N'(1) << 18, "R6");
    chk(seen[2] == 1 && seen[18] == 1, "R6 unused bits", seen[2], 1);

    // R8: settings pulsed for one cycle, lag checked by model
    for (int i = 0; i < 64; i++)
      cycle('1, (i % 3 == 0) ? 32'hFFFF_0000 : '0, (i % 5 == 0) ? 32'h0000_FFFF : '0, "R8");

    // R3 / R8: random traffic
    for (int i = 0; i < 3000; i++)
      cycle($urandom(), $urandom() & $urandom(), $urandom() & $urandom(), "R3");
    cycle('0, '0, '0, "R3");
    cycle('0, '0, '0, "R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule